// File: doc/BRIEF.md
# Vector length configuration unit

This unit executes the instruction that configures vector length. It holds two architectural registers: the maximum vector length (MVL), which software picks as a resource budget, and the current vector length (VL). Each request arrives with its fields already decoded: the destination and source register indices, the source operand value, the loop counter value, a 7-bit immediate, three mode bits (set-MVL, set-VL and vertical-step) and a record bit that asks for a condition nibble. VL always takes the requested value, limited to MVL. The hardware never picks a shorter length of its own.

The source of the requested VL is chosen by which register indices are zero. A zero source index with a nonzero destination index selects the loop counter. Both indices zero selects the immediate. A nonzero source index selects the operand value. The immediate is stored offset by one, so it encodes lengths 1 to 128. When every mode bit is clear, the request only reads VL back. When only the vertical-step bit is set, the request is passed to a separate stepping block as a pulse.

All results are registered and appear one cycle after the request is accepted.

Top module: `vlcfg_unit`

## Requirements
- R1: After reset, `mvl` and `vl` both read 1, `rspValid` is low and `reqReady` is high.
- R2: A request accepted on a clock edge (`reqValid` and `reqReady` high) gives `rspValid` high for exactly the next cycle. When no request is accepted, `rspValid`, `rtWe`, `crWe` and `stepReq` are low and `mvl`/`vl` hold. While `rtWe` is low, `rtData` reads 0. While `crWe` is low, `crNibble` reads 0.
- R3: The effective immediate is the 7-bit field plus one: field 0 means 1 and field 127 means 128.
- R4: With the set-MVL bit high, MVL becomes immediate+1. If the set-VL bit is low, VL becomes MIN(VL, new MVL) and no register writeback occurs.
- R5: With the set-VL bit high, source index 0 and destination index nonzero, VL becomes MIN(MVL, counter) and the same value is written back to the destination (`rtWe` high, `rtWrIdx` equal to the destination index).
- R6: With the set-VL bit high and both indices 0, VL becomes MIN(MVL, immediate+1) and there is no writeback.
- R7: With the set-VL bit high and source index nonzero, VL becomes MIN(MVL, operand value), and the value is written back when the destination index is nonzero.
- R8: With the set-MVL and set-VL bits both high, MVL is updated first and VL is limited against the new MVL in the same request.
- R9: With the record bit high and the request not a step request, `crWe` is high and `crNibble` is {bit3 = 0, bit2 = VL nonzero, bit1 = VL zero, bit0 = overflow}. It describes the new VL, even when the destination index is 0.
- R10: The overflow bit (bit 0) is set only when the record bit is high, VL comes from the immediate or the counter, and the requested value exceeds the (new) MVL. It is never set for the operand-value source.
- R11: With all three mode bits low, MVL and VL do not change, and VL is written back when the destination index is nonzero.
- R12: With only the vertical-step bit high, `stepReq` pulses with the response, MVL/VL do not change, and there is no writeback and no condition nibble.
- R13: With the vertical-step bit high together with the set-MVL or set-VL bit, the request behaves exactly as it would with the vertical-step bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request |
| rtIdx | input | REG_IDX_W | Destination register index |
| raIdx | input | REG_IDX_W | Source register index |
| raVal | input | DATA_W | Source operand value |
| ctrVal | input | DATA_W | Loop counter value |
| immField | input | IMM_W | Encoded immediate (value minus one) |
| msBit | input | 1 | Set-MVL mode bit |
| vsBit | input | 1 | Set-VL mode bit |
| vfBit | input | 1 | Vertical-step mode bit |
| rcBit | input | 1 | Record bit, requests a condition nibble |
| rspValid | output | 1 | Response valid (one cycle per request) |
| rtWe | output | 1 | Writeback enable |
| rtWrIdx | output | REG_IDX_W | Writeback register index |
| rtData | output | DATA_W | Writeback value (zero-extended VL) |
| crWe | output | 1 | Condition nibble valid |
| crNibble | output | 4 | {0, VL nonzero, VL zero, overflow} |
| stepReq | output | 1 | Step request to the stepping block |
| mvl | output | IMM_W+1 | Current MVL |
| vl | output | IMM_W+1 | Current VL |

## Verification
The assertions assume that request fields are stable and meaningful only in a cycle where `reqValid` is high. They also assume that software never asks for a zero MVL, which the offset immediate makes impossible to encode. Given these assumptions, VL can never rise above MVL and the condition nibble can never report VL both zero and nonzero. The stimulus applies every combination of mode bits, zero and nonzero indices and record bit, against immediates and operand/counter values on both sides of every MVL the sequence produces. Each request is driven for one cycle and then released, so every response is followed by an idle cycle in which the hold behaviour is observed.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

  // Where the requested vector length comes from.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,  // current VL, re-limited against MVL
    SRC_IMM  = 2'd1,  // immediate plus one
    SRC_CTR  = 2'd2,  // loop counter
    SRC_RA   = 2'd3   // source operand value
  } vlSrc_e;

  // Strobes from control to datapath, valid in the accepting cycle.
  typedef struct packed {
    logic   accept;
    logic   loadMvl;
    logic   loadVl;
    vlSrc_e vlSrc;
    logic   soCheck;
    logic   rtWrite;
    logic   crWrite;
    logic   step;
  } ctrlStrobe_t;

endpackage

// File: rtl/vlcfg_ctrl.sv
module vlcfg_ctrl
  import vlcfg_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [REG_IDX_W-1:0] rtIdx,
  input  logic [REG_IDX_W-1:0] raIdx,
  input  logic                 msBit,
  input  logic                 vsBit,
  input  logic                 vfBit,
  input  logic                 rcBit,
  output logic                 reqReady,
  output ctrlStrobe_t          strobe
);

  logic readyQ;
  logic accept;
  logic rtZero;
  logic raZero;
  logic isStep;
  logic isGet;

  // Readiness rises on the first edge after reset and stays up.
  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign reqReady = readyQ;

  always_comb begin
    accept = reqValid && readyQ;
    rtZero = (rtIdx == '0);
    raZero = (raIdx == '0);
    // The step bit only counts when neither length is being set.
    isStep = vfBit && !vsBit && !msBit;
    isGet  = !vfBit && !vsBit && !msBit;

    strobe         = '0;
    strobe.accept  = accept;
    strobe.loadMvl = accept && msBit;
    strobe.loadVl  = accept && (vsBit || msBit);

    if (vsBit) begin
      if (raZero) strobe.vlSrc = rtZero ? SRC_IMM : SRC_CTR;
      else        strobe.vlSrc = SRC_RA;
    end else begin
      strobe.vlSrc = SRC_HOLD;
    end

    // Overflow is reported only for the immediate and counter sources.
    strobe.soCheck = rcBit && vsBit && raZero;
    strobe.rtWrite = accept && !rtZero && (vsBit || isGet);
    strobe.crWrite = accept && rcBit && !isStep;
    strobe.step    = accept && isStep;
  end

endmodule

// File: rtl/vlcfg_dpath.sv
module vlcfg_dpath
  import vlcfg_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int IMM_W     = 7,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [IMM_W-1:0]     immField,
  input  logic [DATA_W-1:0]    raVal,
  input  logic [DATA_W-1:0]    ctrVal,
  input  logic [REG_IDX_W-1:0] rtIdx,
  output logic                 rspValid,
  output logic                 rtWe,
  output logic [REG_IDX_W-1:0] rtWrIdx,
  output logic [DATA_W-1:0]    rtData,
  output logic                 crWe,
  output logic [3:0]           crNibble,
  output logic                 stepReq,
  output logic [IMM_W:0]       mvl,
  output logic [IMM_W:0]       vl
);

  localparam int LEN_W = IMM_W + 1;
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic [LEN_W-1:0]  mvlQ;
  logic [LEN_W-1:0]  vlQ;
  logic [LEN_W-1:0]  immPlus;
  logic [LEN_W-1:0]  mvlNext;
  logic [LEN_W-1:0]  vlNext;
  logic [DATA_W-1:0] reqWide;
  logic [DATA_W-1:0] mvlWide;
  logic              reqBelow;
  logic              overflow;
  logic [3:0]        crNext;

  always_comb begin
    immPlus = {1'b0, immField} + LEN_ONE;
    // A new MVL takes effect before VL is limited against it.
    mvlNext = strobe.loadMvl ? immPlus : mvlQ;

    unique case (strobe.vlSrc)
      SRC_IMM:  reqWide = DATA_W'(immPlus);
      SRC_CTR:  reqWide = ctrVal;
      SRC_RA:   reqWide = raVal;
      default:  reqWide = DATA_W'(vlQ);
    endcase

    // The full-width compare keeps large operands from being truncated.
    mvlWide  = DATA_W'(mvlNext);
    reqBelow = (reqWide < mvlWide);
    if (strobe.loadVl) vlNext = reqBelow ? reqWide[LEN_W-1:0] : mvlNext;
    else               vlNext = vlQ;

    overflow = strobe.soCheck && (reqWide > mvlWide);
    crNext   = {1'b0, (vlNext != '0), (vlNext == '0), overflow};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mvlQ     <= LEN_ONE;
      vlQ      <= LEN_ONE;
      rspValid <= 1'b0;
      rtWe     <= 1'b0;
      rtWrIdx  <= '0;
      rtData   <= '0;
      crWe     <= 1'b0;
      crNibble <= '0;
      stepReq  <= 1'b0;
    end else begin
      mvlQ     <= mvlNext;
      vlQ      <= vlNext;
      rspValid <= strobe.accept;
      rtWe     <= strobe.rtWrite;
      rtWrIdx  <= strobe.rtWrite ? rtIdx : '0;
      rtData   <= strobe.rtWrite ? DATA_W'(vlNext) : '0;
      crWe     <= strobe.crWrite;
      crNibble <= strobe.crWrite ? crNext : '0;
      stepReq  <= strobe.step;
    end
  end

  assign mvl = mvlQ;
  assign vl  = vlQ;

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int IMM_W     = 7,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [REG_IDX_W-1:0] rtIdx,
  input  logic [REG_IDX_W-1:0] raIdx,
  input  logic [DATA_W-1:0]    raVal,
  input  logic [DATA_W-1:0]    ctrVal,
  input  logic [IMM_W-1:0]     immField,
  input  logic                 msBit,
  input  logic                 vsBit,
  input  logic                 vfBit,
  input  logic                 rcBit,
  output logic                 rspValid,
  output logic                 rtWe,
  output logic [REG_IDX_W-1:0] rtWrIdx,
  output logic [DATA_W-1:0]    rtData,
  output logic                 crWe,
  output logic [3:0]           crNibble,
  output logic                 stepReq,
  output logic [IMM_W:0]       mvl,
  output logic [IMM_W:0]       vl
);

  ctrlStrobe_t strobe;

  vlcfg_ctrl #(.REG_IDX_W(REG_IDX_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rtIdx    (rtIdx),
    .raIdx    (raIdx),
    .msBit    (msBit),
    .vsBit    (vsBit),
    .vfBit    (vfBit),
    .rcBit    (rcBit),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  vlcfg_dpath #(
    .DATA_W    (DATA_W),
    .IMM_W     (IMM_W),
    .REG_IDX_W (REG_IDX_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .immField (immField),
    .raVal    (raVal),
    .ctrVal   (ctrVal),
    .rtIdx    (rtIdx),
    .rspValid (rspValid),
    .rtWe     (rtWe),
    .rtWrIdx  (rtWrIdx),
    .rtData   (rtData),
    .crWe     (crWe),
    .crNibble (crNibble),
    .stepReq  (stepReq),
    .mvl      (mvl),
    .vl       (vl)
  );

endmodule

// File: rtl/vlcfg_chk.sv
module vlcfg_chk #(
  parameter int DATA_W    = 64,
  parameter int IMM_W     = 7,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 rtWe,
  input logic [DATA_W-1:0]    rtData,
  input logic                 rspValid,
  input logic                 crWe,
  input logic [3:0]           crNibble,
  input logic                 stepReq,
  input logic [IMM_W:0]       mvl,
  input logic [IMM_W:0]       vl
);

  localparam int LEN_MAX = 1 << IMM_W;

  // R4
  vl_within_mvl_chk: assert property (@(posedge clk) disable iff (!rstN)
    vl <= mvl);

  // R3
  mvl_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mvl != '0) && (int'(mvl) <= LEN_MAX));

  // R2
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> (!rspValid && !rtWe && !crWe && !stepReq
                                 && $stable(mvl) && $stable(vl)));

  // R12
  step_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepReq |-> (rspValid && !rtWe && !crWe && $stable(mvl) && $stable(vl)));

  // R9
  cr_consistent_chk: assert property (@(posedge clk) disable iff (!rstN)
    crWe |-> (!crNibble[3] && (crNibble[2] != crNibble[1])
              && (crNibble[1] == (vl == '0))));

  // R5
  rt_matches_vl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rtWe |-> (rtData == DATA_W'(vl)));

endmodule

bind vlcfg_unit vlcfg_chk #(
  .DATA_W    (DATA_W),
  .IMM_W     (IMM_W),
  .REG_IDX_W (REG_IDX_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rtWe     (rtWe),
  .rtData   (rtData),
  .rspValid (rspValid),
  .crWe     (crWe),
  .crNibble (crNibble),
  .stepReq  (stepReq),
  .mvl      (mvl),
  .vl       (vl)
);

// File: tb/sim_vlcfg_unit.sv
`timescale 1ns/1ps
module sim_vlcfg_unit;

  localparam int DATA_W    = 64;
  localparam int IMM_W     = 7;
  localparam int REG_IDX_W = 5;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 reqValid = 1'b0;
  logic                 reqReady;
  logic [REG_IDX_W-1:0] rtIdx = '0;
  logic [REG_IDX_W-1:0] raIdx = '0;
  logic [DATA_W-1:0]    raVal = '0;
  logic [DATA_W-1:0]    ctrVal = '0;
  logic [IMM_W-1:0]     immField = '0;
  logic                 msBit = 1'b0;
  logic                 vsBit = 1'b0;
  logic                 vfBit = 1'b0;
  logic                 rcBit = 1'b0;
  logic                 rspValid;
  logic                 rtWe;
  logic [REG_IDX_W-1:0] rtWrIdx;
  logic [DATA_W-1:0]    rtData;
  logic                 crWe;
  logic [3:0]           crNibble;
  logic                 stepReq;
  logic [IMM_W:0]       mvl;
  logic [IMM_W:0]       vl;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  longint unsigned mMvl = 1;
  longint unsigned mVl  = 1;

  always #5 clk = ~clk;

  vlcfg_unit #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_IDX_W(REG_IDX_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .rtIdx(rtIdx), .raIdx(raIdx), .raVal(raVal), .ctrVal(ctrVal),
    .immField(immField), .msBit(msBit), .vsBit(vsBit), .vfBit(vfBit),
    .rcBit(rcBit), .rspValid(rspValid), .rtWe(rtWe), .rtWrIdx(rtWrIdx),
    .rtData(rtData), .crWe(crWe), .crNibble(crNibble), .stepReq(stepReq),
    .mvl(mvl), .vl(vl)
  );

  task automatic chk(input string tag, input string what,
                     input longint unsigned got, input longint unsigned exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // One request: drive at a falling edge, check the registered response
  // at the next falling edge, then check the idle cycle that follows.
  task automatic runOp(input bit vf, input bit vs, input bit ms, input bit rc,
                       input int rt, input int ra, input int imm,
                       input longint unsigned opVal, input string forceTag);
    longint unsigned imm1, req, newMvl, vlN, expRt;
    bit step, isGet, so, useSo, expRtWe, expCrWe;
    string tag;
    imm1  = longint'(imm) + 1;
    step  = vf && !vs && !ms;
    isGet = !vf && !vs && !ms;
    newMvl = ms ? imm1 : mMvl;
    so = 1'b0;
    useSo = 1'b0;
    req = 0;
    if (vs) begin
      if (ra == 0) begin
        req = (rt != 0) ? opVal : imm1;
        useSo = 1'b1;
      end else begin
        req = opVal;
      end
      vlN = (req < newMvl) ? req : newMvl;
      so  = rc && useSo && (req > newMvl);
    end else if (ms) begin
      vlN = (mVl < newMvl) ? mVl : newMvl;
    end else begin
      vlN = mVl;
    end
    expRtWe = (rt != 0) && (vs || isGet);
    expCrWe = rc && !step;
    expRt   = expRtWe ? vlN : 0;

    if (forceTag != "")   tag = forceTag;
    else if (step)        tag = "R12";
    else if (vf)          tag = "R13";
    else if (vs && ms)    tag = "R8";
    else if (vs && ra != 0) tag = "R7";
    else if (vs && rt != 0) tag = "R5";
    else if (vs)          tag = "R6";
    else if (ms)          tag = "R4";
    else                  tag = "R11";

    @(negedge clk);
    reqValid = 1'b1;
    vfBit = vf; vsBit = vs; msBit = ms; rcBit = rc;
    rtIdx = REG_IDX_W'(rt); raIdx = REG_IDX_W'(ra);
    immField = IMM_W'(imm);
    raVal = opVal; ctrVal = opVal;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2", "rspValid", rspValid, 1);
    chk(tag, "mvl", mvl, newMvl);
    chk(tag, "vl", vl, vlN);
    chk(tag, "rtWe", rtWe, expRtWe);
    chk(tag, "rtData", rtData, expRt);
    if (expRtWe) chk(tag, "rtWrIdx", rtWrIdx, rt);
    chk(tag, "stepReq", stepReq, step);
    chk("R9", "crWe", crWe, expCrWe);
    if (expCrWe) begin
      chk("R9", "crNibble[3:1]", crNibble[3:1],
          {1'b0, vlN != 0, vlN == 0});
      chk("R10", "crNibble[0]", crNibble[0], so);
    end else begin
      chk("R2", "crNibble", crNibble, 0);
    end
    mMvl = newMvl;
    mVl  = vlN;
    @(negedge clk);
    chk("R2", "idle rspValid", rspValid, 0);
    chk("R2", "idle vl", vl, mVl);
  endtask

  function automatic int immPick(input int k);
    case (k)
      0: return 0;
      1: return 3;
      2: return 7;
      3: return 63;
      default: return 127;
    endcase
  endfunction

  function automatic longint unsigned valPick(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 5;
      3: return 100;
      default: return 64'd1 << 40;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "mvl", mvl, 1);
    chk("R1", "vl", vl, 1);
    chk("R1", "rspValid", rspValid, 0);
    chk("R1", "reqReady", reqReady, 1);

    // R3 immediate ends: field 127 means 128, field 0 means 1
    runOp(0, 1, 1, 1, 0, 0, 127, 0, "R3");
    runOp(0, 1, 1, 1, 0, 0, 0, 0, "R3");
    // R10: counter request above MVL raises overflow, operand does not
    runOp(0, 1, 1, 0, 0, 0, 9, 0, "R10");
    runOp(0, 1, 0, 1, 4, 0, 0, 500, "R10");
    runOp(0, 1, 0, 1, 4, 6, 0, 500, "R10");

    for (int mode = 0; mode < 8; mode++)
      for (int rtSel = 0; rtSel < 2; rtSel++)
        for (int raSel = 0; raSel < 2; raSel++)
          for (int rc = 0; rc < 2; rc++)
            for (int ik = 0; ik < 5; ik++)
              for (int vk = 0; vk < 5; vk++)
                runOp(mode[2], mode[1], mode[0], rc[0],
                      rtSel * 3, raSel * 7, immPick(ik), valPick(vk), "");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule